// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder with Dead Time

This block turns four logic-level bridge commands into registered gate-enable signals for a two-leg full bridge: one high-side and one low-side switch per leg. The commands are a high-side chop input, a low-side chop input, a direction input and a synchronous-rectification enable. From their combination the block produces forward and reverse drive, slow decay chopped on either side, fast decay, coast and dynamic brake. Direction picks which leg's high-side switch and which leg's low-side switch carry the drive current.

Each leg has its own dead-time guard. A switch may turn on only after its complement in the same leg has been off for the programmed number of clock cycles. If the complement has been off for longer than that, the turn-on is not delayed. Turn-offs are never delayed. A charge-pump-ready input holds every gate off until the gate supply is usable. Per-switch inhibit inputs from the fault logic force single gates off.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four gate outputs are low.
- R2: Index 0 is leg A and index 1 is leg B. With dir=1 and both chop inputs high, the A high side and the B low side are on. With dir=0, the B high side and the A low side are on.
- R3: With sync_en=0, a low hi_pwm turns off the driving high-side switch one clock later. The driving low-side switch stays on and the complement of the switch that went off stays off.
- R4: With sync_en=1, a low hi_pwm turns on the low-side switch in the same leg as the driving high-side switch, subject to the dead time.
- R5: A low lo_pwm turns off the driving low-side switch one clock later. With sync_en=1, the high-side switch in the same leg turns on, subject to the dead time.
- R6: With hi_pwm, lo_pwm and sync_en all low, every gate output is low one clock later (coast).
- R7: sync_en=1, hi_pwm=0, lo_pwm=1 ends with both low sides on and both high sides off. sync_en=1, hi_pwm=1, lo_pwm=0 ends with both high sides on and both low sides off.
- R8: The high-side and low-side outputs of one leg are never high in the same cycle.
- R9: A switch goes high only after its complement has been low for at least max(D,1) consecutive cycles, where D is the effective dead time. If the complement has already been low that long, the switch goes high one clock after it is requested.
- R10: A dead_cfg value of all ones selects the default dead time of CLK_MHZ*DEFAULT_DEAD_US cycles (600 cycles with the defaults). Any other value is taken as a cycle count.
- R11: While pump_ready is low, all gates go low one clock later and stay low. When pump_ready rises, the commanded gates turn on one clock later.
- R12: Each inhibit bit forces its own gate low one clock later and leaves the other gates untouched.
- R13: With hi_pwm, lo_pwm and sync_en held high, toggling dir switches all four gates. Every turn-on waits out the dead time (four-quadrant fast decay).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_pwm | input | 1 | High-side chop command |
| lo_pwm | input | 1 | Low-side chop command |
| dir | input | 1 | Drive direction, 1 = leg A to leg B |
| sync_en | input | 1 | Synchronous rectification enable |
| pump_ready | input | 1 | Gate supply ready; low holds all gates off |
| inhibit_hi | input | 2 | Per-leg high-side force-off from the fault logic |
| inhibit_lo | input | 2 | Per-leg low-side force-off from the fault logic |
| dead_cfg | input | DEAD_W | Dead time in cycles; all ones selects the default |
| gate_hi | output | 2 | High-side gate enables, bit 0 leg A, bit 1 leg B |
| gate_lo | output | 2 | Low-side gate enables, bit 0 leg A, bit 1 leg B |

## Verification
The hardest case to reach from the ports is a turn-on that lands inside the dead-time window of a switch that has only just turned off. Reaching it needs a one-cycle change of command that hands a leg from one side to the other. The stimulus produces this by flipping dir, or by dropping a chop input with rectification on, while the bridge is in steady drive. The outputs are sampled on the last cycle of the window and on the first cycle after it. Zero, small and default dead times are each covered, and a turn-on after a long idle period confirms that no delay is added.

// File: rtl/hbridge_gate_pkg.sv
package hbridge_gate_pkg;
   localparam int unsigned NUM_LEGS = 2;
   localparam int unsigned LEG_A    = 0;
   localparam int unsigned LEG_B    = 1;

   typedef struct packed {
      logic hi;
      logic lo;
   } leg_cmd_t;

   function automatic int unsigned sat_max(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
   import hbridge_gate_pkg::*;
(
   input  logic                hi_pwm,
   input  logic                lo_pwm,
   input  logic                dir,
   input  logic                sync_en,
   input  logic                pump_ready,
   input  logic [NUM_LEGS-1:0] inhibit_hi,
   input  logic [NUM_LEGS-1:0] inhibit_lo,
   output leg_cmd_t            want [NUM_LEGS]
);
   for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
      // the source leg takes the high-side drive for the chosen direction
      logic is_src;
      logic raw_hi;
      logic raw_lo;
      assign is_src = (k == LEG_A) ? dir : ~dir;
      always_comb begin
         if (is_src) begin
            raw_hi = hi_pwm;
            raw_lo = sync_en & ~hi_pwm;
         end else begin
            raw_hi = sync_en & ~lo_pwm;
            raw_lo = lo_pwm;
         end
         want[k].hi = raw_hi & pump_ready & ~inhibit_hi[k];
         want[k].lo = raw_lo & pump_ready & ~inhibit_lo[k];
      end
   end
endmodule

// File: rtl/hb_dead_sel.sv
module hb_dead_sel #(
   parameter int unsigned DEAD_W       = 10,
   parameter int unsigned DEFAULT_DEAD = 600,
   parameter bit          ONES_DEFAULT = 1'b1
) (
   input  logic [DEAD_W-1:0] dead_cfg,
   output logic [DEAD_W-1:0] dead_eff
);
   localparam logic [DEAD_W-1:0] DEF_V = DEAD_W'(DEFAULT_DEAD);

   if (ONES_DEFAULT) begin : g_map_ones
      always_comb begin
         if (&dead_cfg) dead_eff = DEF_V;
         else           dead_eff = dead_cfg;
      end
   end else begin : g_literal
      assign dead_eff = dead_cfg;
   end
endmodule

// File: rtl/hb_dead_leg.sv
module hb_dead_leg
   import hbridge_gate_pkg::*;
#(
   parameter int unsigned DEAD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  leg_cmd_t          want,
   input  logic [DEAD_W-1:0] dead_eff,
   output logic              gate_hi,
   output logic              gate_lo
);
   localparam logic [DEAD_W-1:0] CMAX = DEAD_W'(sat_max(DEAD_W));

   // index 0 = high side, 1 = low side
   logic [1:0]        out_q;
   logic [1:0]        out_d;
   logic [1:0]        req;
   logic [DEAD_W-1:0] off_cnt [2];

   assign req = {want.lo, want.hi};

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int C = 1 - s;
      logic comp_clear;
      assign comp_clear = ~out_q[C] & (off_cnt[C] >= dead_eff);
      assign out_d[s]   = req[s] & ~req[C] & comp_clear;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              off_cnt[s] <= CMAX;
         else if (out_d[s])       off_cnt[s] <= '0;
         else if (off_cnt[s] != CMAX) off_cnt[s] <= off_cnt[s] + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 2'b00;
      else        out_q <= out_d;
   end

   assign gate_hi = out_q[0];
   assign gate_lo = out_q[1];
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
   import hbridge_gate_pkg::*;
#(
   parameter int unsigned DEAD_W          = 10,
   parameter int unsigned CLK_MHZ         = 100,
   parameter int unsigned DEFAULT_DEAD_US = 6,
   parameter bit          ONES_DEFAULT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_pwm,
   input  logic              lo_pwm,
   input  logic              dir,
   input  logic              sync_en,
   input  logic              pump_ready,
   input  logic [1:0]        inhibit_hi,
   input  logic [1:0]        inhibit_lo,
   input  logic [DEAD_W-1:0] dead_cfg,
   output logic [1:0]        gate_hi,
   output logic [1:0]        gate_lo
);
   localparam int unsigned DEFAULT_DEAD = CLK_MHZ * DEFAULT_DEAD_US;

   if (DEAD_W < 2 || DEAD_W > 16) begin : g_bad_w
      $error("hbridge_gate_ctrl: DEAD_W out of range");
   end
   if (DEFAULT_DEAD >= sat_max(DEAD_W)) begin : g_bad_def
      $error("hbridge_gate_ctrl: default dead time does not fit DEAD_W");
   end
   if (NUM_LEGS != 2) begin : g_bad_legs
      $error("hbridge_gate_ctrl: full bridge needs two legs");
   end

   leg_cmd_t          want [NUM_LEGS];
   logic [DEAD_W-1:0] dead_eff;

   hb_cmd_decode u_dec (
      .hi_pwm     (hi_pwm),
      .lo_pwm     (lo_pwm),
      .dir        (dir),
      .sync_en    (sync_en),
      .pump_ready (pump_ready),
      .inhibit_hi (inhibit_hi),
      .inhibit_lo (inhibit_lo),
      .want       (want)
   );

   hb_dead_sel #(
      .DEAD_W       (DEAD_W),
      .DEFAULT_DEAD (DEFAULT_DEAD),
      .ONES_DEFAULT (ONES_DEFAULT)
   ) u_sel (
      .dead_cfg (dead_cfg),
      .dead_eff (dead_eff)
   );

   for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
      hb_dead_leg #(.DEAD_W(DEAD_W)) u_leg (
         .clk      (clk),
         .rst_n    (rst_n),
         .want     (want[k]),
         .dead_eff (dead_eff),
         .gate_hi  (gate_hi[k]),
         .gate_lo  (gate_lo[k])
      );
   end
endmodule

// File: rtl/hbridge_gate_ctrl_chk.sv
module hbridge_gate_ctrl_chk #(
   parameter int unsigned DEAD_W          = 10,
   parameter int unsigned CLK_MHZ         = 100,
   parameter int unsigned DEFAULT_DEAD_US = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hi_pwm,
   input logic              lo_pwm,
   input logic              sync_en,
   input logic              pump_ready,
   input logic [1:0]        inhibit_hi,
   input logic [1:0]        inhibit_lo,
   input logic [DEAD_W-1:0] dead_cfg,
   input logic [1:0]        gate_hi,
   input logic [1:0]        gate_lo
);
   localparam logic [DEAD_W-1:0] CMAX = {DEAD_W{1'b1}};
   localparam logic [DEAD_W-1:0] DEFV = DEAD_W'(CLK_MHZ * DEFAULT_DEAD_US);

   logic [DEAD_W-1:0] need;
   always_comb begin
      if (&dead_cfg)            need = DEFV;
      else if (dead_cfg == '0)  need = DEAD_W'(1);
      else                      need = dead_cfg;
   end

   // R11: supply not ready blanks the bridge
   p_pump_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_ready |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

   // R6: coast
   p_coast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_pwm && !lo_pwm && !sync_en) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

   for (genvar k = 0; k < 2; k++) begin : g_leg
      logic [DEAD_W-1:0] lo_run;
      logic [DEAD_W-1:0] hi_run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_run <= CMAX;
            hi_run <= CMAX;
         end else begin
            lo_run <= gate_lo[k] ? '0 : ((lo_run == CMAX) ? CMAX : lo_run + 1'b1);
            hi_run <= gate_hi[k] ? '0 : ((hi_run == CMAX) ? CMAX : hi_run + 1'b1);
         end
      end

      // R8: no shoot-through
      p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate_hi[k] && gate_lo[k]));

      // R9: dead time before a high-side turn-on
      p_dead_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_hi[k]) |-> (lo_run >= $past(need)));

      // R9: dead time before a low-side turn-on
      p_dead_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_lo[k]) |-> (hi_run >= $past(need)));

      // R12: per-gate inhibit
      p_inh_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
         inhibit_hi[k] |=> !gate_hi[k]);
      p_inh_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
         inhibit_lo[k] |=> !gate_lo[k]);
   end
endmodule

bind hbridge_gate_ctrl hbridge_gate_ctrl_chk #(
   .DEAD_W          (DEAD_W),
   .CLK_MHZ         (CLK_MHZ),
   .DEFAULT_DEAD_US (DEFAULT_DEAD_US)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hi_pwm     (hi_pwm),
   .lo_pwm     (lo_pwm),
   .sync_en    (sync_en),
   .pump_ready (pump_ready),
   .inhibit_hi (inhibit_hi),
   .inhibit_lo (inhibit_lo),
   .dead_cfg   (dead_cfg),
   .gate_hi    (gate_hi),
   .gate_lo    (gate_lo)
);

// File: tb/hbridge_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_tb_top;
   localparam int DW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hi_pwm = 1'b0;
   logic          lo_pwm = 1'b0;
   logic          dir = 1'b1;
   logic          sync_en = 1'b0;
   logic          pump_ready = 1'b1;
   logic [1:0]    inhibit_hi = 2'b00;
   logic [1:0]    inhibit_lo = 2'b00;
   logic [DW-1:0] dead_cfg = DW'(4);
   logic [1:0]    gate_hi;
   logic [1:0]    gate_lo;

   int n_tests = 0;
   int n_fail  = 0;
   int shoot   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   hbridge_gate_ctrl #(.DEAD_W(DW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hi_pwm     (hi_pwm),
      .lo_pwm     (lo_pwm),
      .dir        (dir),
      .sync_en    (sync_en),
      .pump_ready (pump_ready),
      .inhibit_hi (inhibit_hi),
      .inhibit_lo (inhibit_lo),
      .dead_cfg   (dead_cfg),
      .gate_hi    (gate_hi),
      .gate_lo    (gate_lo)
   );

   // R8 monitor, sampled mid-cycle
   always @(negedge clk)
      if (rst_n && ((gate_hi & gate_lo) != 2'b00)) shoot++;

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic h, input logic l, input logic d, input logic s);
      @(negedge clk);
      hi_pwm = h; lo_pwm = l; dir = d; sync_en = s;
   endtask

   task automatic chk(input logic [1:0] eh, input logic [1:0] el, input string tag);
      n_tests++;
      if (gate_hi !== eh || gate_lo !== el) begin
         n_fail++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
      end
   endtask

   task automatic t_reset();
      #1 chk(2'b00, 2'b00, "R1 during reset");
      @(negedge clk); rst_n = 1'b1;
      edges(1);
      chk(2'b00, 2'b00, "R1 first cycle after reset");
   endtask

   task automatic t_direction();
      drive(1, 1, 1, 0);
      edges(1);
      chk(2'b01, 2'b10, "R2 forward, R9 no delay after idle");
      drive(1, 1, 0, 0);
      edges(1);
      chk(2'b00, 2'b00, "R13 reverse turn-off immediate");
      edges(3);
      chk(2'b00, 2'b00, "R9 still inside dead time");
      edges(1);
      chk(2'b10, 2'b01, "R2 reverse after dead time");
   endtask

   task automatic t_hi_chop();
      drive(1, 1, 1, 0);
      edges(10);
      chk(2'b01, 2'b10, "R2 forward steady");
      drive(0, 1, 1, 0);
      edges(1);
      chk(2'b00, 2'b10, "R3 high-side chop, no rectification");
      edges(6);
      chk(2'b00, 2'b10, "R3 complement stays off");
      drive(1, 1, 1, 0);
      edges(10);
      drive(0, 1, 1, 1);
      edges(1);
      chk(2'b00, 2'b10, "R4 high off, low waits");
      edges(3);
      chk(2'b00, 2'b10, "R4 within dead time");
      edges(1);
      chk(2'b00, 2'b11, "R4 and R7 both low sides on");
   endtask

   task automatic t_lo_chop();
      drive(1, 1, 1, 0);
      edges(10);
      drive(1, 0, 1, 0);
      edges(1);
      chk(2'b01, 2'b00, "R5 low-side chop");
      edges(6);
      drive(1, 0, 1, 1);
      edges(1);
      chk(2'b11, 2'b00, "R5 and R7 both high sides on");
   endtask

   task automatic t_coast();
      drive(0, 0, 1, 0);
      edges(1);
      chk(2'b00, 2'b00, "R6 coast");
   endtask

   task automatic t_inhibit();
      drive(1, 1, 1, 0);
      edges(10);
      @(negedge clk); inhibit_hi = 2'b01;
      edges(1);
      chk(2'b00, 2'b10, "R12 inhibit A high only");
      @(negedge clk); inhibit_hi = 2'b00; inhibit_lo = 2'b10;
      edges(1);
      chk(2'b01, 2'b00, "R12 inhibit B low, A high returns");
      @(negedge clk); inhibit_lo = 2'b00;
      edges(1);
      chk(2'b01, 2'b10, "R12 release");
   endtask

   task automatic t_pump();
      @(negedge clk); pump_ready = 1'b0;
      edges(1);
      chk(2'b00, 2'b00, "R11 pump not ready");
      edges(20);
      chk(2'b00, 2'b00, "R11 held off");
      @(negedge clk); pump_ready = 1'b1;
      edges(1);
      chk(2'b01, 2'b10, "R11 resume");
   endtask

   task automatic t_zero_dead();
      @(negedge clk); dead_cfg = '0;
      drive(1, 1, 0, 0);
      edges(1);
      chk(2'b00, 2'b00, "R9 zero dead, gap cycle");
      edges(1);
      chk(2'b10, 2'b01, "R9 zero dead, one-cycle gap");
   endtask

   task automatic t_fast_decay();
      @(negedge clk); dead_cfg = DW'(3);
      drive(1, 1, 1, 1);
      edges(10);
      for (int i = 0; i < 6; i++) begin
         logic d;
         d = (i % 2 == 0) ? 1'b0 : 1'b1;
         drive(1, 1, d, 1);
         edges(1);
         chk(2'b00, 2'b00, "R13 toggle all off");
         edges(2);
         chk(2'b00, 2'b00, "R13 dead window");
         edges(1);
         if (d) chk(2'b01, 2'b10, "R13 forward on");
         else   chk(2'b10, 2'b01, "R13 reverse on");
      end
   endtask

   task automatic t_default_dead();
      @(negedge clk); dead_cfg = '1;
      drive(1, 1, 1, 0);
      edges(700);
      drive(1, 1, 0, 0);
      edges(600);
      chk(2'b00, 2'b00, "R10 default dead time not elapsed");
      edges(1);
      chk(2'b10, 2'b01, "R10 default dead time 600 cycles");
   endtask

   task automatic finish_run();
      n_tests++;
      if (shoot != 0) begin
         n_fail++;
         $display("FAIL R8: shoot-through cycles=%0d expected 0", shoot);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_direction();
      t_hi_chop();
      t_lo_chop();
      t_coast();
      t_inhibit();
      t_pump();
      t_zero_dead();
      t_fast_decay();
      t_default_dead();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule